// File: doc/BRIEF.md
# DMA Master Control and Fault Status Register

This block is a single 32-bit control register that sits beside a multi-channel DMA engine. It holds one global run bit and two sticky fault flags. One flag latches address errors reported by the engine. The other latches non-maskable interrupt events. From these three bits and from each channel's own enable and transfer-end inputs, it computes a per-channel permit vector. The engine uses that vector to decide whether a channel may move data.

Software cannot set either fault flag. To clear a flag, software must first read the register and see that flag at 1, and then write 0 to it. A per-flag armed bit records that read. The armed bit is used up by the next write to the register, whatever that write contains. If either flag is set, or the run bit is 0, every channel is held at once. The error interrupt output is a level that follows the address-error flag.

Top module: `dma_master_ctl`

## Requirements
- R1: After reset, the register reads 0x0000_0000, `ch_permit` is all zeros and `err_irq` is 0.
- R2: Register layout: bit 0 is the run bit, which reads back as written. Bit 1 is the NMI fault flag. Bit 2 is the address-error fault flag. Bits 31:3 always read 0 and ignore writes.
- R3: `ch_permit[i]` is 1 only when the run bit is 1, `ch_de[i]` is 1, `ch_te[i]` is 0 and both fault flags are 0. The `ch_de` and `ch_te` inputs act on the output in the same cycle. A register change acts on the output in the cycle after the edge that stores it.
- R4: A pulse on `addr_err_evt` sets the address-error flag at the next clock edge. `err_irq` equals that flag at all times.
- R5: A pulse on `nmi_evt` sets the NMI flag at the next clock edge, whether the run bit is 0 or 1.
- R6: A CPU write of 1 to either fault bit never sets that flag.
- R7: A write of 0 to a fault bit clears the flag only if that flag was armed. A flag is armed by a read that returned it as 1. The next write of any value disarms it. A write of 0 with no arm leaves the flag unchanged.
- R8: If a set event and an armed clearing write for the same flag land on the same edge, the flag stays 1.
- R9: Writing 0 to the run bit drops every channel's permit in the cycle after the write edge, even while the channels are enabled.
- R10: Each flag has its own arm. A read that returns one flag as 1 and the other as 0 arms only the first. A later write of 0 clears only that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_rd | input | 1 | CPU read strobe, one cycle per access |
| reg_wr | input | 1 | CPU write strobe, one cycle per access |
| reg_wdata | input | 32 | CPU write data |
| reg_rdata | output | 32 | Register contents, combinational |
| addr_err_evt | input | 1 | Address error reported by the engine |
| nmi_evt | input | 1 | Non-maskable interrupt event |
| ch_de | input | NUM_CH | Per-channel enable bits |
| ch_te | input | NUM_CH | Per-channel transfer-end bits |
| ch_permit | output | NUM_CH | Per-channel transfer permit |
| err_irq | output | 1 | Error interrupt request level |

## Verification
The block's results fall due at one of two times. Any change driven by a clock edge shows up one cycle after its stimulus: a write, a set event, or the arm taken by a read. Changes on `ch_de` or `ch_te` show on `ch_permit` in the same cycle. The bench drives every input just after a rising edge and holds it through the next edge. It checks registered results one time step after that edge. It samples read data and same-cycle permit values while the strobe or input is still applied. This ensures every comparison looks at a settled value.

// File: rtl/dma_master_ctl.sv
module dma_master_ctl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              addr_err_evt,
  input  logic              nmi_evt,
  input  logic [NUM_CH-1:0] ch_de,
  input  logic [NUM_CH-1:0] ch_te,
  output logic [NUM_CH-1:0] ch_permit,
  output logic              err_irq
);
  localparam int RUN_B = 0;
  localparam int NMI_B = 1;
  localparam int AER_B = 2;

  logic run_q, nmi_q, aer_q;
  logic nmi_arm_q, aer_arm_q;
  logic nmi_clr, aer_clr, go;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[31:3];

  assign nmi_clr = reg_wr && !reg_wdata[NMI_B] && nmi_arm_q;
  assign aer_clr = reg_wr && !reg_wdata[AER_B] && aer_arm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else if (reg_wr) run_q <= reg_wdata[RUN_B];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nmi_q <= 1'b0;
    else if (nmi_evt) nmi_q <= 1'b1;
    else if (nmi_clr) nmi_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) aer_q <= 1'b0;
    else if (addr_err_evt) aer_q <= 1'b1;
    else if (aer_clr) aer_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_arm_q <= 1'b0;
      aer_arm_q <= 1'b0;
    end else if (reg_wr) begin
      nmi_arm_q <= 1'b0;
      aer_arm_q <= 1'b0;
    end else if (reg_rd) begin
      if (nmi_q) nmi_arm_q <= 1'b1;
      if (aer_q) aer_arm_q <= 1'b1;
    end
  end

  assign reg_rdata = {29'd0, aer_q, nmi_q, run_q};
  assign go        = run_q && !nmi_q && !aer_q;
  assign ch_permit = {NUM_CH{go}} & ch_de & ~ch_te;
  assign err_irq   = aer_q;

  p_aer_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_evt |=> err_irq);
  p_nmi_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> reg_rdata[NMI_B]);
  p_no_sw_set_nmi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_evt |=> !$rose(reg_rdata[NMI_B]));
  p_no_sw_set_aer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_err_evt |=> !$rose(reg_rdata[AER_B]));
  p_nmi_clr_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[NMI_B]) |-> $past(reg_wr && !reg_wdata[NMI_B] && nmi_arm_q));
  p_aer_clr_armed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[AER_B]) |-> $past(reg_wr && !reg_wdata[AER_B] && aer_arm_q));
  p_fault_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[NMI_B] || reg_rdata[AER_B]) |-> (ch_permit == '0));
  p_stop_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_wdata[RUN_B]) |=> (ch_permit == '0));
endmodule

// File: tb/dma_master_ctl_tb_top.sv
module dma_master_ctl_tb_top;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_rd = 0, reg_wr = 0, addr_err_evt = 0, nmi_evt = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] ch_de = 0, ch_te = 0, ch_permit;
  logic err_irq;
  int checks = 0, failures = 0;
  logic [31:0] q;

  always #2 clk = ~clk;

  dma_master_ctl #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_err_evt(addr_err_evt),
    .nmi_evt(nmi_evt), .ch_de(ch_de), .ch_te(ch_te), .ch_permit(ch_permit),
    .err_irq(err_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d; step(); reg_wr = 0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1; #1 d = reg_rdata; step(); reg_rd = 0;
  endtask

  task automatic pulse_nmi();
    nmi_evt = 1; step(); nmi_evt = 0;
  endtask

  task automatic pulse_aer();
    addr_err_evt = 1; step(); addr_err_evt = 0;
  endtask

  task automatic t_reset();
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 permit", ch_permit, 0);
    chk("R1 irq", err_irq, 0);
  endtask

  task automatic t_layout();
    wr(32'hFFFF_FFFF);
    rd(q); chk("R2 R6 all ones write", q, 32'h1);
    chk("R6 irq", err_irq, 0);
    wr(32'h0);
    rd(q); chk("R2 run clear", q, 32'h0);
  endtask

  task automatic t_permit();
    wr(32'h1);
    ch_de = 4'hF; ch_te = 4'h0; #1 chk("R3 all on", ch_permit, 4'hF);
    ch_te = 4'h5; #1 chk("R3 te mask", ch_permit, 4'hA);
    ch_de = 4'h3; ch_te = 4'h0; #1 chk("R3 de mask", ch_permit, 4'h3);
    step();
  endtask

  task automatic t_run_stop();
    ch_de = 4'hF; ch_te = 4'h0; #1 chk("R9 before", ch_permit, 4'hF);
    step();
    wr(32'h0); chk("R9 after stop", ch_permit, 4'h0);
  endtask

  task automatic t_nmi();
    pulse_nmi(); chk("R5 set while idle", reg_rdata, 32'h2);
    rd(q);                                  // arms NMI flag
    wr(32'h3); chk("R6 write one keeps", reg_rdata, 32'h3);
    chk("R3 fault blocks", ch_permit, 4'h0);
    wr(32'h1); chk("R7 unarmed zero", reg_rdata, 32'h3);
    rd(q); chk("R7 read value", q, 32'h3);
    wr(32'h1); chk("R7 armed clear", reg_rdata, 32'h1);
    chk("R3 resume", ch_permit, 4'hF);
  endtask

  task automatic t_aer();
    pulse_aer(); chk("R4 irq", err_irq, 1);
    chk("R4 rdata", reg_rdata, 32'h5);
    chk("R3 aer blocks", ch_permit, 4'h0);
    rd(q);
    wr(32'h1); chk("R7 aer cleared", reg_rdata, 32'h1);
    chk("R4 irq clear", err_irq, 0);
  endtask

  task automatic t_set_wins();
    pulse_nmi(); rd(q);
    reg_wr = 1; reg_wdata = 32'h1; nmi_evt = 1; step();
    reg_wr = 0; nmi_evt = 0;
    chk("R8 set wins", reg_rdata, 32'h3);
    rd(q); wr(32'h1); chk("R8 later clear", reg_rdata, 32'h1);
  endtask

  task automatic t_indep();
    pulse_nmi(); rd(q);                     // arms NMI only
    pulse_aer();
    wr(32'h1); chk("R10 nmi only cleared", reg_rdata, 32'h5);
    rd(q); wr(32'h1); chk("R10 aer cleared", reg_rdata, 32'h1);
  endtask

  initial begin
    #(200000 * 4);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1; step();
    t_reset();
    t_layout();
    t_permit();
    t_run_stop();
    t_nmi();
    t_aer();
    t_set_wins();
    t_indep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule